// File: doc/BRIEF.md
# Power-Domain Switch Sequencer

This block drives the switch-on and switch-off handshake for ten power domains outside the processor cluster. A client gives a 12-bit domain register offset and an on/off flag. The block maps the offset to a domain number and first raises a global enable line. One cycle later it raises exactly one bit of a 20-bit request word. It then checks an acknowledge word and two copies of the power-status word. The first check comes at once, and each later check follows a fixed wait. The wait is counted in clock cycles, and the default gives 10 us at 50 MHz.

The operation finishes when the acknowledge and both status copies agree with the request, or when the check limit has been used up. In both cases the request word and the enable line drop together, and a one-cycle done pulse reports the result with an error flag. An offset that names no domain finishes with an error straight away and never touches the request word. The client may start a new command only while the block is idle.

Top module: `pd_switch_ctrl`

## Requirements
- R1: After reset, `req_word` is 0, `ctrl_en` is 0, `done` is 0, `op_err` is 0 and `cmd_ready` is 1.
- R2: When `cmd_offset` is not one of the ten domain offsets, an accepted command gives `done` with `op_err`=1 in the next cycle. `req_word` and `ctrl_en` stay 0 throughout.
- R3: The domain offsets map to domain numbers as follows: 0x210→0, 0x230→1, 0x238→2, 0x23C→3, 0x298→4, 0x29C→5, 0x2C4→6, 0x2C0→7, 0x214→8, 0x2CC→9. In the cycle after a valid command is accepted, `ctrl_en` is 1 and `req_word` is still 0. One cycle later `req_word` has only bit d set (on request) or only bit d+10 set (off request), where d is the domain number.
- R4: Domains 0..9 read status bit 7, 21, 5, 3, 20, 24, 23, 22, 4 and 25 respectively. A check passes only when `ack_word & req_word` is nonzero and that bit equals `cmd_on` in both `stat_a` and `stat_b`. If any one of these conditions is missing, the check fails.
- R5: The first check is made in the cycle the request appears. Each failed check is followed by TICK_CYCLES idle cycles before the next check. A passing check gives `done` in the next cycle with `op_err`=0.
- R6: If MAX_POLLS+1 checks fail, the wait after the last of them ends the operation with `done` and `op_err`=1.
- R7: In the `done` cycle, `req_word` is 0 and `ctrl_en` is 0. `done` lasts one cycle, and `cmd_ready` is 1 in the cycle after it.
- R8: `cmd_ready` is 0 from acceptance until `done`. A command presented in that time is ignored and leaves `req_word` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken when `cmd_ready` is 1 |
| cmd_offset | input | 12 | Domain register offset |
| cmd_on | input | 1 | 1 = switch on, 0 = switch off |
| cmd_ready | output | 1 | Idle and able to take a command |
| ack_word | input | 20 | Acknowledge bits, aligned with `req_word` |
| stat_a | input | 32 | First power-status copy |
| stat_b | input | 32 | Second power-status copy |
| req_word | output | 20 | Request bits: on in 0..9, off in 10..19 |
| ctrl_en | output | 1 | Global control enable for the whole operation |
| done | output | 1 | One-cycle completion pulse |
| op_err | output | 1 | Result with `done`: 1 = error |

## Verification
The assertions check on every cycle the properties that hold at all times. The request word never has more than one bit set, and a request never stands without the enable. At the done pulse both the request and the enable are clear, the pulse lasts one cycle, and an idle block has nothing raised. The bench scenarios cover what the assertions cannot see. These are the offset-to-domain and domain-to-status-bit mappings, the on/off bit split, and the three-way success condition with each part withheld in turn. They also cover the exact latency of the check interval and of the timeout, and a command presented while the block is busy being refused.

// File: rtl/pd_switch_pkg.sv
package pd_switch_pkg;

    localparam int NUM_DOM = 10;
    localparam int REQ_W   = 2 * NUM_DOM;
    localparam int STAT_W  = 32;
    localparam int OFS_W   = 12;
    localparam int IDX_W   = $clog2(NUM_DOM);
    localparam int POS_W   = $clog2(STAT_W);
    localparam int RBIT_W  = $clog2(REQ_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_POLL,
        ST_WAIT,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } dom_sel_t;

    typedef struct packed {
        logic             on;
        logic [IDX_W-1:0] idx;
    } dom_op_t;

    // Offset to domain number; hit=0 for an unknown offset.
    function automatic dom_sel_t map_offset(input logic [OFS_W-1:0] ofs);
        dom_sel_t s;
        s.hit = 1'b1;
        case (ofs)
            12'h210: s.idx = IDX_W'(0);
            12'h230: s.idx = IDX_W'(1);
            12'h238: s.idx = IDX_W'(2);
            12'h23C: s.idx = IDX_W'(3);
            12'h298: s.idx = IDX_W'(4);
            12'h29C: s.idx = IDX_W'(5);
            12'h2C4: s.idx = IDX_W'(6);
            12'h2C0: s.idx = IDX_W'(7);
            12'h214: s.idx = IDX_W'(8);
            12'h2CC: s.idx = IDX_W'(9);
            default: begin
                s.hit = 1'b0;
                s.idx = '0;
            end
        endcase
        return s;
    endfunction

    // Domain number to the bit it occupies in both status copies.
    function automatic logic [POS_W-1:0] status_pos(input logic [IDX_W-1:0] idx);
        case (idx)
            IDX_W'(0): return POS_W'(7);
            IDX_W'(1): return POS_W'(21);
            IDX_W'(2): return POS_W'(5);
            IDX_W'(3): return POS_W'(3);
            IDX_W'(4): return POS_W'(20);
            IDX_W'(5): return POS_W'(24);
            IDX_W'(6): return POS_W'(23);
            IDX_W'(7): return POS_W'(22);
            IDX_W'(8): return POS_W'(4);
            IDX_W'(9): return POS_W'(25);
            default:   return '0;
        endcase
    endfunction

    // Request bit: on requests in the low half, off requests in the high half.
    function automatic logic [RBIT_W-1:0] request_bit(input dom_op_t op);
        if (op.on)
            return RBIT_W'(op.idx);
        return RBIT_W'(op.idx) + RBIT_W'(NUM_DOM);
    endfunction

endpackage

// File: rtl/pd_decode.sv
module pd_decode
    import pd_switch_pkg::*;
(
    input  logic [OFS_W-1:0] offset,
    output dom_sel_t         sel
);
    always_comb sel = map_offset(offset);
endmodule

// File: rtl/pd_match.sv
module pd_match
    import pd_switch_pkg::*;
(
    input  dom_op_t           op,
    input  logic [REQ_W-1:0]  req,
    input  logic [REQ_W-1:0]  ack,
    input  logic [STAT_W-1:0] stat_a,
    input  logic [STAT_W-1:0] stat_b,
    output logic              ok
);
    logic [NUM_DOM-1:0] tap_a;
    logic [NUM_DOM-1:0] tap_b;
    logic               unused_stat;

    // One fixed tap per domain into each status copy.
    for (genvar g = 0; g < NUM_DOM; g++) begin : g_tap
        localparam logic [POS_W-1:0] TAP = status_pos(IDX_W'(g));
        assign tap_a[g] = stat_a[TAP];
        assign tap_b[g] = stat_b[TAP];
    end

    assign unused_stat = ^{stat_a, stat_b};

    always_comb begin
        ok = (|(ack & req))
             && (tap_a[op.idx] == op.on)
             && (tap_b[op.idx] == op.on);
    end
endmodule

// File: rtl/pd_pacer.sv
module pd_pacer #(
    parameter int TICK_CYCLES = 500,
    parameter int MAX_POLLS   = 10000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic tick_last,
    output logic expired
);
    localparam int TW = $clog2(TICK_CYCLES + 1);
    localparam int PW = $clog2(MAX_POLLS + 2);

    logic [TW-1:0] tick_q;
    logic [PW-1:0] poll_q;

    assign tick_last = (tick_q == TW'(TICK_CYCLES - 1));
    // The wait now ending is the one after check number poll_q+1.
    assign expired   = tick_last && (poll_q >= PW'(MAX_POLLS));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            tick_q <= '0;
            poll_q <= '0;
        end else if (run) begin
            if (tick_last) begin
                tick_q <= '0;
                poll_q <= poll_q + 1'b1;
            end else begin
                tick_q <= tick_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pd_switch_ctrl.sv
module pd_switch_ctrl
    import pd_switch_pkg::*;
#(
    parameter int TICK_CYCLES = 500,
    parameter int MAX_POLLS   = 10000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [OFS_W-1:0]  cmd_offset,
    input  logic              cmd_on,
    output logic              cmd_ready,
    input  logic [REQ_W-1:0]  ack_word,
    input  logic [STAT_W-1:0] stat_a,
    input  logic [STAT_W-1:0] stat_b,
    output logic [REQ_W-1:0]  req_word,
    output logic              ctrl_en,
    output logic              done,
    output logic              op_err
);
    seq_state_e       state_q;
    dom_op_t          op_q;
    dom_sel_t         sel;
    logic [REQ_W-1:0] req_q;
    logic             en_q;
    logic             err_q;
    logic             match_ok;
    logic             tick_last;
    logic             expired;

    pd_decode u_decode (
        .offset (cmd_offset),
        .sel    (sel)
    );

    pd_match u_match (
        .op     (op_q),
        .req    (req_q),
        .ack    (ack_word),
        .stat_a (stat_a),
        .stat_b (stat_b),
        .ok     (match_ok)
    );

    pd_pacer #(
        .TICK_CYCLES (TICK_CYCLES),
        .MAX_POLLS   (MAX_POLLS)
    ) u_pacer (
        .clk       (clk),
        .rst       (rst),
        .clear     (state_q == ST_ARM),
        .run       (state_q == ST_WAIT),
        .tick_last (tick_last),
        .expired   (expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= '0;
            req_q   <= '0;
            en_q    <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        if (sel.hit) begin
                            op_q    <= '{on: cmd_on, idx: sel.idx};
                            en_q    <= 1'b1;
                            err_q   <= 1'b0;
                            state_q <= ST_ARM;
                        end else begin
                            err_q   <= 1'b1;
                            state_q <= ST_DONE;
                        end
                    end
                end
                ST_ARM: begin
                    req_q   <= REQ_W'(1) << request_bit(op_q);
                    state_q <= ST_POLL;
                end
                ST_POLL: begin
                    if (match_ok) begin
                        req_q   <= '0;
                        en_q    <= 1'b0;
                        err_q   <= 1'b0;
                        state_q <= ST_DONE;
                    end else begin
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (expired) begin
                        req_q   <= '0;
                        en_q    <= 1'b0;
                        err_q   <= 1'b1;
                        state_q <= ST_DONE;
                    end else if (tick_last) begin
                        state_q <= ST_POLL;
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cmd_ready = (state_q == ST_IDLE);
    assign done      = (state_q == ST_DONE);
    assign req_word  = req_q;
    assign ctrl_en   = en_q;
    assign op_err    = err_q;
endmodule

// File: rtl/pd_switch_ctrl_chk.sv
module pd_switch_ctrl_chk
    import pd_switch_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cmd_ready,
    input logic             done,
    input logic [REQ_W-1:0] req_word,
    input logic             ctrl_en
);
    p_req_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_word));

    p_req_needs_en_r3: assert property (@(posedge clk) disable iff (rst)
        (req_word != '0) |-> ctrl_en);

    p_done_clears_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (req_word == '0) && !ctrl_en);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && cmd_ready);

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> (req_word == '0) && !ctrl_en && !done);
endmodule

bind pd_switch_ctrl pd_switch_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_ready (cmd_ready),
    .done      (done),
    .req_word  (req_word),
    .ctrl_en   (ctrl_en)
);

// File: tb/pd_switch_ctrl_bench.sv
module pd_switch_ctrl_bench;
    localparam int TICK = 4;
    localparam int MAXP = 3;
    localparam int T_OK  = 3;
    localparam int T_OUT = 2 + (MAXP + 1) * (1 + TICK);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [11:0] cmd_offset = '0;
    logic        cmd_on = 1'b0;
    logic        cmd_ready;
    logic [19:0] ack_word = '0;
    logic [31:0] stat_a = '0;
    logic [31:0] stat_b = '0;
    logic [19:0] req_word;
    logic        ctrl_en;
    logic        done;
    logic        op_err;

    int checks = 0;
    int errors = 0;

    int          o_n;
    logic [19:0] o_req1, o_req2, o_reqd, o_reqpoke;
    logic        o_en1, o_end, o_err, o_busy_ready, o_after_ready, o_after_en;

    always #10 clk = ~clk;

    pd_switch_ctrl #(.TICK_CYCLES(TICK), .MAX_POLLS(MAXP)) u_pd_switch_ctrl (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_offset(cmd_offset),
        .cmd_on(cmd_on), .cmd_ready(cmd_ready), .ack_word(ack_word),
        .stat_a(stat_a), .stat_b(stat_b), .req_word(req_word),
        .ctrl_en(ctrl_en), .done(done), .op_err(op_err)
    );

    function automatic int dom_of(input logic [11:0] o);
        case (o)
            12'h210: return 0;  12'h230: return 1;  12'h238: return 2;
            12'h23C: return 3;  12'h298: return 4;  12'h29C: return 5;
            12'h2C4: return 6;  12'h2C0: return 7;  12'h214: return 8;
            12'h2CC: return 9;  default: return -1;
        endcase
    endfunction

    function automatic int pos_of(input int d);
        int tbl [10] = '{7, 21, 5, 3, 20, 24, 23, 22, 4, 25};
        return tbl[d];
    endfunction

    function automatic logic [19:0] req_of(input int d, input bit on);
        return 20'(1) << (on ? d : d + 10);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Issue one command; observe the cycles that follow it.
    task automatic send(input logic [11:0] ofs, input bit on, input int flip_at,
                        input logic [31:0] flip_val, input bit poke);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_offset = ofs; cmd_on = on;
        @(posedge clk);
        o_n = -1;
        for (int n = 1; n < 200; n++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            if (n == 1) begin o_req1 = req_word; o_en1 = ctrl_en; end
            if (n == 2) o_req2 = req_word;
            if (n == flip_at) begin stat_a = flip_val; stat_b = flip_val; end
            if (poke && n == 4) begin
                o_busy_ready = cmd_ready;
                cmd_valid = 1'b1; cmd_offset = 12'h2CC; cmd_on = ~on;
            end
            if (poke && n == 5) o_reqpoke = req_word;
            if (done) begin
                o_n = n; o_err = op_err; o_reqd = req_word; o_end = ctrl_en;
                break;
            end
        end
        @(negedge clk);
        o_after_ready = cmd_ready;
        o_after_en = ctrl_en;
    endtask

    task automatic t_reset();
        check("R1 req_word", req_word, 0);
        check("R1 ctrl_en", ctrl_en, 0);
        check("R1 done", done, 0);
        check("R1 op_err", op_err, 0);
        check("R1 cmd_ready", cmd_ready, 1);
    endtask

    task automatic t_bad_offset(input logic [11:0] ofs);
        ack_word = '1; stat_a = '1; stat_b = '1;
        send(ofs, 1'b1, -1, 0, 1'b0);
        check("R2 latency", o_n, 1);
        check("R2 op_err", o_err, 1);
        check("R2 req_word", o_reqd, 0);
        check("R2 ctrl_en", o_end, 0);
    endtask

    task automatic t_on_all();
        logic [11:0] ofs [10] = '{12'h210, 12'h214, 12'h230, 12'h238, 12'h23C,
                                  12'h298, 12'h29C, 12'h2C0, 12'h2C4, 12'h2CC};
        for (int k = 0; k < 10; k++) begin
            int d = dom_of(ofs[k]);
            ack_word = '1;
            stat_a = 32'(1) << pos_of(d);
            stat_b = 32'(1) << pos_of(d);
            send(ofs[k], 1'b1, -1, 0, 1'b0);
            check("R3 enable before request: req", o_req1, 0);
            check("R3 enable before request: en", o_en1, 1);
            check("R3 on request bit", o_req2, req_of(d, 1'b1));
            check("R4 R5 success latency", o_n, T_OK);
            check("R4 success op_err", o_err, 0);
            check("R7 cleared req at done", o_reqd, 0);
            check("R7 cleared en at done", o_end, 0);
            check("R7 ready after done", o_after_ready, 1);
        end
    endtask

    task automatic t_off(input logic [11:0] ofs);
        int d = dom_of(ofs);
        ack_word = '1;
        stat_a = ~(32'(1) << pos_of(d));
        stat_b = ~(32'(1) << pos_of(d));
        send(ofs, 1'b0, -1, 0, 1'b0);
        check("R3 off request bit", o_req2, req_of(d, 1'b0));
        check("R4 off success latency", o_n, T_OK);
        check("R4 off op_err", o_err, 0);
    endtask

    task automatic t_timeout_ack();
        int d = dom_of(12'h23C);
        ack_word = ~req_of(d, 1'b1);
        stat_a = 32'(1) << pos_of(d);
        stat_b = 32'(1) << pos_of(d);
        send(12'h23C, 1'b1, -1, 0, 1'b1);
        check("R4 R6 ack missing timeout latency", o_n, T_OUT);
        check("R6 timeout op_err", o_err, 1);
        check("R7 timeout req cleared", o_reqd, 0);
        check("R7 timeout en cleared", o_end, 0);
        check("R8 busy not ready", o_busy_ready, 0);
        check("R8 busy command ignored", o_reqpoke, req_of(d, 1'b1));
        check("R8 no extra operation", o_after_en, 0);
    endtask

    task automatic t_timeout_statb();
        int d = dom_of(12'h298);
        ack_word = '1;
        stat_a = 32'(1) << pos_of(d);
        stat_b = '0;
        send(12'h298, 1'b1, -1, 0, 1'b0);
        check("R4 second copy mismatch latency", o_n, T_OUT);
        check("R4 second copy mismatch op_err", o_err, 1);
    endtask

    task automatic t_delayed();
        int d = dom_of(12'h2C4);
        ack_word = '1;
        stat_a = '0; stat_b = '0;
        send(12'h2C4, 1'b1, 3, 32'(1) << pos_of(d), 1'b0);
        check("R5 second check latency", o_n, T_OK + 1 + TICK);
        check("R5 delayed op_err", o_err, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_bad_offset(12'h220);
        t_bad_offset(12'h000);
        t_on_all();
        t_off(12'h214);
        t_off(12'h29C);
        t_timeout_ack();
        t_timeout_statb();
        t_delayed();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule